// File: doc/BRIEF.md
# Bus Turnaround Gap Inserter

This block guards one memory bank against transactions that follow each other too closely. A transaction sequencer asks for the bank with a request line. The block answers with a grant and drives the bank's active-low chip select low for the length of the transaction. When the sequencer reports that the transaction has completed, the block raises chip select. It then holds the bank idle for a programmable number of clock cycles before it grants the next request. The idle gap gives the memory time to release its data bus after a read, and it also guarantees a minimum chip-select high time between accesses.

The gap is the same for every pair of accesses, whether they are reads or writes, because the block never sees the direction of an access. Chip select always toggles high between two accesses, even when the sequencer has the next request waiting. The 4-bit turnaround setting N gives a gap of N+1 cycles, so 0 gives one cycle and 15 gives sixteen. The setting is captured when a transaction completes. A request that arrives while a transaction or a gap is in progress is remembered until it can be granted.

Top module: `bank_turnaround_gap`

## Requirements
- R1: After reset the block is idle: `grant_o` is 0 while no request is present, and `cs_n_o` is 1.
- R2: When the block is idle with no gap running, an asserted `next_req_i` gives `grant_o`=1 in the same cycle. `cs_n_o` is 0 (bank selected) from the next cycle until the cycle after the completion pulse.
- R3: In the cycle after a `xfer_done_i` pulse during a transaction, `cs_n_o` goes to 1. It stays at 1 for at least N+1 cycles, where N is the value of `turn_cfg_i` in the cycle of the pulse.
- R4: A request that is waiting when the gap ends is granted exactly N+2 cycles after the completion pulse. That is 2 cycles for N=0 and 17 cycles for N=15.
- R5: `turn_cfg_i` is used only in the cycle of the completion pulse. Changing it during the gap does not change the gap length.
- R6: A `next_req_i` pulse of a single cycle that arrives during a transaction or a gap is held and granted once when the gap ends. No second grant follows from it.
- R7: A `xfer_done_i` pulse while no transaction is active has no effect. A request in the following cycle is granted at once.
- R8: `grant_o` is never high in two consecutive cycles. No grant occurs while a transaction or a gap is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| turn_cfg_i | input | CFG_W | Turnaround setting N; the gap is N+1 cycles |
| xfer_done_i | input | 1 | One-cycle pulse marking completion of the current transaction |
| next_req_i | input | 1 | Request for the next transaction on the bank |
| grant_o | output | 1 | One-cycle grant of the bank to the sequencer |
| cs_n_o | output | 1 | Active-low bank chip select, high when the bank is not selected |

## Verification
Two events can fall in the same cycle. A request can arrive in the very cycle the gap counter expires, and a completion pulse can coincide with a fresh request or with a change of the turnaround setting. The bench provokes both with random request, completion and setting streams, plus directed runs in which the request is held across the whole gap or pulsed once inside it. Every cycle, a bench reference model judges whether the grant lands exactly on the cycle after expiry and whether chip select stays high through the captured gap.

// File: rtl/tgi_pkg.sv
package tgi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_GAP  = 2'd2
  } tgi_state_e;

  // Number of idle cycles inserted for a setting value.
  function automatic int unsigned gap_cycles(input int unsigned setting);
    return setting + 1;
  endfunction

  // Chip-select level for a state: selected (low) only while busy.
  function automatic logic cs_level(input tgi_state_e st);
    return (st != ST_BUSY);
  endfunction
endpackage

// File: rtl/tgi_gap_counter.sv
module tgi_gap_counter #(
  parameter int unsigned CFG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             run_i,
  output logic             expire_o
);
  localparam logic [CFG_W-1:0] ONE = {{(CFG_W-1){1'b0}}, 1'b1};

  logic [CFG_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
    end else if (load_i) begin
      cnt_q <= cfg_i;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign expire_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/tgi_req_hold.sv
module tgi_req_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic grant_i,
  output logic pending_o,
  output logic want_o
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (grant_i) begin
      pend_q <= 1'b0;
    end else if (req_i) begin
      pend_q <= 1'b1;
    end
  end

  assign pending_o = pend_q;
  assign want_o    = req_i || pend_q;
endmodule

// File: rtl/tgi_seq_fsm.sv
module tgi_seq_fsm
  import tgi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic want_i,
  input  logic done_i,
  input  logic expire_i,
  output logic grant_o,
  output logic gap_start_o,
  output logic in_gap_o,
  output logic cs_n_o
);
  tgi_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    grant_o     = 1'b0;
    gap_start_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (want_i) begin
          grant_o = 1'b1;
          state_d = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (done_i) begin
          gap_start_o = 1'b1;
          state_d     = ST_GAP;
        end
      end
      ST_GAP: begin
        if (expire_i) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign in_gap_o = (state_q == ST_GAP);
  assign cs_n_o   = cs_level(state_q);
endmodule

// File: rtl/bank_turnaround_gap.sv
module bank_turnaround_gap #(
  parameter int unsigned CFG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] turn_cfg_i,
  input  logic             xfer_done_i,
  input  logic             next_req_i,
  output logic             grant_o,
  output logic             cs_n_o
);
  // Named internal events, visible to the bound checker.
  logic gap_start;
  logic gap_expire;
  logic in_gap;
  logic want;
  logic req_pending;

  tgi_req_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (next_req_i),
    .grant_i   (grant_o),
    .pending_o (req_pending),
    .want_o    (want)
  );

  tgi_gap_counter #(.CFG_W(CFG_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (gap_start),
    .cfg_i    (turn_cfg_i),
    .run_i    (in_gap),
    .expire_o (gap_expire)
  );

  tgi_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .want_i      (want),
    .done_i      (xfer_done_i),
    .expire_i    (gap_expire),
    .grant_o     (grant_o),
    .gap_start_o (gap_start),
    .in_gap_o    (in_gap),
    .cs_n_o      (cs_n_o)
  );
endmodule

// File: rtl/bank_turnaround_gap_chk.sv
module bank_turnaround_gap_chk #(
  parameter int unsigned CFG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] turn_cfg_i,
  input logic             next_req_i,
  input logic             grant_o,
  input logic             cs_n_o,
  input logic             gap_start,
  input logic             gap_expire,
  input logic             req_pending
);
  logic [5:0]       since_q;
  logic [CFG_W-1:0] cfg_l_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      cfg_l_q <= '0;
      seen_q  <= 1'b0;
    end else if (gap_start) begin
      since_q <= 6'd1;
      cfg_l_q <= turn_cfg_i;
      seen_q  <= 1'b1;
    end else if (since_q != 6'h3F) begin
      since_q <= since_q + 6'd1;
    end
  end

  p_grant_selects_r2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |=> !cs_n_o);

  p_gap_deselects_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gap_start |=> cs_n_o);

  p_gap_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o && seen_q) |-> (int'(since_q) >= int'(cfg_l_q) + 2));

  p_held_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_expire && (req_pending || next_req_i)) |=> grant_o);

  p_expiry_point_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_expire && seen_q) |-> (int'(since_q) == int'(cfg_l_q) + 1));

  p_pend_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |=> !req_pending);

  p_one_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |=> !grant_o);
endmodule

bind bank_turnaround_gap bank_turnaround_gap_chk #(.CFG_W(CFG_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .turn_cfg_i  (turn_cfg_i),
  .next_req_i  (next_req_i),
  .grant_o     (grant_o),
  .cs_n_o      (cs_n_o),
  .gap_start   (gap_start),
  .gap_expire  (gap_expire),
  .req_pending (req_pending)
);

// File: tb/bank_turnaround_gap_tb_top.sv
`timescale 1ns/1ps
module bank_turnaround_gap_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cfg = 4'd0;
  logic       done = 1'b0;
  logic       req = 1'b0;
  logic       grant_o;
  logic       cs_n_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  bit last_grant;
  bit last_cs;

  // Reference model state: 0 idle, 1 transaction, 2 gap.
  int m_st = 0;
  int m_cnt = 15;
  bit m_pend = 0;

  always #2.5 clk = ~clk;

  bank_turnaround_gap #(.CFG_W(4)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .turn_cfg_i  (cfg),
    .xfer_done_i (done),
    .next_req_i  (req),
    .grant_o     (grant_o),
    .cs_n_o      (cs_n_o)
  );

  // Cycles from completion pulse to grant of a waiting request.
  function automatic int exp_wait(input int setting);
    return (setting + 1) + 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit r, input bit d, input logic [3:0] c, input string tag);
    bit eg;
    bit ecs;
    @(negedge clk);
    req = r; done = d; cfg = c;
    #1;
    eg  = (m_st == 0) && (r || m_pend);
    ecs = (m_st != 1);
    chk(grant_o == eg, {tag, " grant"}, int'(grant_o), int'(eg));
    chk(cs_n_o == ecs, {tag, " cs_n"}, int'(cs_n_o), int'(ecs));
    last_grant = grant_o;
    last_cs    = cs_n_o;
    @(posedge clk);
    case (m_st)
      0: if (eg) begin m_st = 1; m_pend = 0; end
      1: begin
        if (r) m_pend = 1;
        if (d) begin m_st = 2; m_cnt = int'(c); end
      end
      default: begin
        if (r) m_pend = 1;
        if (m_cnt == 0) m_st = 0; else m_cnt--;
      end
    endcase
  endtask

  task automatic flush();
    for (int i = 0; i < 18; i++) step(0, 0, 4'd0, "R1");
  endtask

  task automatic measure(input int c);
    int n;
    bit cs_ok;
    step(1, 0, 4'd0, "R2");
    chk(last_grant == 1, "R2 idle grant", int'(last_grant), 1);
    step(0, 0, 4'd0, "R2");
    chk(last_cs == 0, "R2 selected", int'(last_cs), 0);
    step(0, 1, 4'(c), "R3");
    n = 0; cs_ok = 1;
    do begin
      step(1, 0, 4'($urandom_range(15)), "R5");
      n++;
      if (!last_cs) cs_ok = 0;
    end while (!last_grant && n < 40);
    chk(n == exp_wait(c), "R4 grant delay", n, exp_wait(c));
    chk(cs_ok, "R3 cs high through gap", int'(cs_ok), 1);
    step(0, 1, 4'd0, "R3");
    flush();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    step(0, 0, 4'd0, "R1");
    chk(last_grant == 0, "R1 no grant", int'(last_grant), 0);
    chk(last_cs == 1, "R1 cs high", int'(last_cs), 1);

    // R4/R5 gap lengths at extremes and middle, setting scrambled mid-gap
    measure(0);
    measure(15);
    measure(5);

    // R6: single-cycle request during gap held, granted once
    begin
      int n;
      int grants;
      step(1, 0, 4'd0, "R6");
      step(0, 1, 4'd3, "R6");
      step(1, 0, 4'd9, "R6");
      n = 1;
      while (!last_grant && n < 40) begin
        step(0, 0, 4'd9, "R6");
        n++;
      end
      chk(n == exp_wait(3), "R6 held grant delay", n, exp_wait(3));
      step(0, 1, 4'd0, "R6");
      grants = 0;
      for (int i = 0; i < 18; i++) begin
        step(0, 0, 4'd0, "R6");
        if (last_grant) grants++;
      end
      chk(grants == 0, "R6 no repeat grant", grants, 0);
    end

    // R7: completion pulse while idle is ignored
    step(0, 1, 4'd15, "R7");
    chk(last_cs == 1, "R7 cs stays high", int'(last_cs), 1);
    step(1, 0, 4'd0, "R7");
    chk(last_grant == 1, "R7 immediate grant", int'(last_grant), 1);
    step(0, 1, 4'd0, "R7");
    flush();

    // Random phase: request and completion collide with gap expiry
    for (int i = 0; i < 4000; i++) begin
      bit r;
      bit d;
      r = ($urandom_range(99) < 40);
      d = ($urandom_range(99) < 30);
      step(r, d, 4'($urandom_range(15)),
           (m_st == 2) ? "R3" : ((m_st == 1) ? "R8" : "R2"));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule